// File: doc/BRIEF.md
# Memory Channel Select and Address Normalizer

This block sits after range decoding in a memory address path. It takes a system address that already belongs to this node, the number of address bits that node interleaving consumes, and this node's controller-select configuration. From these it picks one of two memory channels and rebuilds the address as that channel sees it. The configuration arrives as plain inputs, so a register file elsewhere owns it.

The channel choice works through a fixed priority. Ganged operation comes first, then an upper address range bound to a fixed channel, then several channel-interleave schemes, one of which XORs a parity hash of address bits 20 to 16 into the result. Normalizing removes an offset, which is either the range base, the upper-range offset or the offset of a memory hole above 4 GiB. It then drops the address bits that node and channel interleaving used, so each channel sees a dense address space. All results are registered, and they appear one clock after the inputs. An error flag is raised when the chosen channel is not below the channel count that is in use.

Top module: `msn_chan_norm`

## Requirements
- R1: The high-range flag is 1 only when high-range mode is on, ganged mode is off and the address is at or above the select base, which is the select-base field shifted left by 27. Otherwise it is 0.
- R2: In ganged mode the channel equals address bit 3, whatever the other settings are.
- R3: When the high range is selected, and the block is not ganged, the channel equals the programmed high channel.
- R4: When channel interleave is on and the interleave code is 0, and neither of the cases above applies, the channel equals address bit 6.
- R5: Interleave codes 2 and 3 give the XOR parity of address bits [20:16]. With code 3 this parity is XORed with address bit 9, and with code 2 it is XORed with address bit 6.
- R6: With code 1 the channel is address bit (12 + node-interleave bit count). With interleave off and high-range mode on, the channel is the inverse of the high channel. In every other case it is channel 0.
- R7: The hole offset is the hole field shifted left by 23. It is subtracted when the hole is valid and the address is at or above 2^32. In the high range this also requires the select base to lie below 2^32.
- R8: When the hole offset is not used, the block subtracts the select-base offset field shifted left by 26 in the high range, and the range base in all other cases.
- R9: After the subtraction, the node-interleave bit count (0 to 3) of bits are deleted starting at bit 12. Bits [11:0] are kept and the higher bits shift down.
- R10: Channel interleave bits are removed only when interleave is on, the high range is not selected and ganged mode is off. Codes 0 and 2 delete bit 6, code 1 deletes bit 12 and code 3 deletes bit 9.
- R11: The error output is 1 exactly when the chosen channel number is greater than or equal to the configured channel count.
- R12: The outputs are registered and reflect the inputs sampled at the previous rising edge. While reset is low at an edge, all outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_addr | input | 48 | System address, after range decode |
| node_ilv_bits | input | 2 | Number of address bits used by node interleaving (0 to 3) |
| range_base | input | 48 | Base address of the matched DRAM range |
| hi_rng_en | input | 1 | Enables the high address range |
| hi_chan | input | 1 | Channel bound to the high range |
| sel_ilv_en | input | 1 | Enables channel interleaving |
| gang_en | input | 1 | Ganged mode: both channels operate as one |
| ilv_code | input | 2 | Channel interleave scheme code |
| sel_base | input | 21 | Select base, address bits [47:27] |
| sel_base_ofs | input | 22 | High-range offset, address bits [47:26] |
| hole_ofs | input | 8 | Memory hole offset, address bits [30:23] |
| hole_valid | input | 1 | Memory hole offset is in force |
| chan_count | input | 2 | Number of channels populated |
| chan | output | 1 | Selected channel |
| hi_sel | output | 1 | High range selected |
| chan_addr | output | 48 | Normalized channel-local address |
| chan_err | output | 1 | Selected channel not below chan_count |

## Verification
The bench builds the block with its default parameters: a 48-bit address, a 2-bit node-interleave count, and field positions at 27, 26 and 23. With this width, addresses above 2^32 can be reached, which the hole-offset choice needs. It also allows a select base at exactly 2^32, which shows that the hole rule is qualified in the high range. The 2-bit count brings in node removal of up to three bits, and that removal combines with channel-bit deletion at bit 12.

// File: rtl/msn_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the channel select and normalizer.
// Assumes: two channels, so a channel number is one bit wide.
package msn_pkg;
    // Interleave scheme codes; bit 1 selects hashing, bit 0 the partner bit
    localparam logic [1:0] ILV_BIT6  = 2'd0;
    localparam logic [1:0] ILV_BIT12 = 2'd1;
    localparam logic [1:0] ILV_HASH6 = 2'd2;
    localparam logic [1:0] ILV_HASH9 = 2'd3;

    // Which offset is subtracted from the system address
    typedef enum logic [1:0] {
        OFS_RANGE = 2'd0,
        OFS_HIGH  = 2'd1,
        OFS_HOLE  = 2'd2
    } ofs_src_e;
endpackage

// File: rtl/msn_chan_pick.sv
`timescale 1ns/1ps
// Channel chooser: decides the high-range flag and the channel through a
// fixed priority (ganged, high range, interleave schemes, fallback).
// Assumes: the select base is given as address bits above SEL_LSB.
module msn_chan_pick
    import msn_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int NODE_W  = 2,
    parameter int SEL_LSB = 27,
    parameter int ILV_LSB = 12
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [NODE_W-1:0]         node_bits_i,
    input  logic                      hi_rng_en_i,
    input  logic                      hi_chan_i,
    input  logic                      ilv_en_i,
    input  logic                      gang_en_i,
    input  logic [1:0]                code_i,
    input  logic [ADDR_W-SEL_LSB-1:0] sel_base_i,
    output logic                      hi_sel_o,
    output logic                      chan_o
);
    localparam int HASH_LO = 16;
    localparam int HASH_HI = 20;

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] ilv_shift;
    logic              hash;

    // Expand the select base and prepare the interleave-bit view
    always_comb begin
        base_addr = {sel_base_i, {SEL_LSB{1'b0}}};
        ilv_shift = addr_i >> (ILV_LSB + int'(node_bits_i));
        hash      = ^addr_i[HASH_HI:HASH_LO];
    end

    // Prioritized channel decision
    always_comb begin
        hi_sel_o = hi_rng_en_i && !gang_en_i && (addr_i >= base_addr);
        if (gang_en_i)
            chan_o = addr_i[3];
        else if (hi_sel_o)
            chan_o = hi_chan_i;
        else if (ilv_en_i && code_i == ILV_BIT6)
            chan_o = addr_i[6];
        else if (ilv_en_i && code_i[1])
            chan_o = hash ^ (code_i[0] ? addr_i[9] : addr_i[6]);
        else if (ilv_en_i)
            chan_o = ilv_shift[0];
        else if (hi_rng_en_i)
            chan_o = ~hi_chan_i;
        else
            chan_o = 1'b0;
    end
endmodule

// File: rtl/msn_offset_sel.sv
`timescale 1ns/1ps
// Offset chooser: picks range base, high-range offset or hole offset and
// returns the full-width value to subtract.
// Assumes: fields arrive as address bits above their LSB positions.
module msn_offset_sel
    import msn_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int SEL_LSB  = 27,
    parameter int OFS_LSB  = 26,
    parameter int HOLE_LSB = 23,
    parameter int HOLE_W   = 8
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      hi_sel_i,
    input  logic [ADDR_W-SEL_LSB-1:0] sel_base_i,
    input  logic [ADDR_W-OFS_LSB-1:0] sel_ofs_i,
    input  logic [HOLE_W-1:0]         hole_ofs_i,
    input  logic                      hole_valid_i,
    input  logic [ADDR_W-1:0]         range_base_i,
    output ofs_src_e                  src_o,
    output logic [ADDR_W-1:0]         offset_o
);
    localparam int FOUR_G   = 32;
    localparam int BASE_CUT = FOUR_G - SEL_LSB;

    logic above_4g;
    logic base_low;

    // Classify the address and select base against the 4 GiB line
    always_comb begin
        above_4g = |addr_i[ADDR_W-1:FOUR_G];
        base_low = ~|sel_base_i[ADDR_W-SEL_LSB-1:BASE_CUT];
    end

    // Choose the offset source and expand it
    always_comb begin
        if (hole_valid_i && above_4g && (!hi_sel_i || base_low))
            src_o = OFS_HOLE;
        else if (hi_sel_i)
            src_o = OFS_HIGH;
        else
            src_o = OFS_RANGE;
        case (src_o)
            OFS_HOLE: offset_o = ADDR_W'({hole_ofs_i, {HOLE_LSB{1'b0}}});
            OFS_HIGH: offset_o = {sel_ofs_i, {OFS_LSB{1'b0}}};
            default:  offset_o = range_base_i;
        endcase
    end
endmodule

// File: rtl/msn_squeeze.sv
`timescale 1ns/1ps
// Bit squeezer: deletes node-interleave bits above bit 11, then the
// channel-interleave bit chosen by the scheme code when stripping is on.
// Assumes: node bit count is at most 3 and the input is offset-adjusted.
module msn_squeeze
    import msn_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int NODE_W  = 2,
    parameter int ILV_LSB = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NODE_W-1:0] node_bits_i,
    input  logic              strip_chan_i,
    input  logic [1:0]        code_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LOW_KEEP = (ONE << ILV_LSB) - ONE;

    logic [ADDR_W-1:0] node_out;
    logic [ADDR_W-1:0] keep_mask;
    int                pos;

    // Close the gap left by node interleaving
    always_comb begin
        node_out = ((addr_i >> (ILV_LSB + int'(node_bits_i))) << ILV_LSB)
                 | (addr_i & LOW_KEEP);
    end

    // Close the gap left by channel interleaving
    always_comb begin
        if (!code_i[0])
            pos = 6;
        else if (code_i == ILV_BIT12)
            pos = 12;
        else
            pos = 9;
        keep_mask = (ONE << pos) - ONE;
        if (strip_chan_i)
            addr_o = ((node_out >> (pos + 1)) << pos) | (node_out & keep_mask);
        else
            addr_o = node_out;
    end
endmodule

// File: rtl/msn_chan_norm.sv
`timescale 1ns/1ps
// Channel select and normalizer top: picks a channel, subtracts the
// proper offset, squeezes out interleave bits and registers the result.
// Assumes: the address has already been matched to this node's range.
module msn_chan_norm
    import msn_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int NODE_W   = 2,
    parameter int SEL_LSB  = 27,
    parameter int OFS_LSB  = 26,
    parameter int HOLE_LSB = 23,
    parameter int HOLE_W   = 8,
    parameter int CNT_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         sys_addr,
    input  logic [NODE_W-1:0]         node_ilv_bits,
    input  logic [ADDR_W-1:0]         range_base,
    input  logic                      hi_rng_en,
    input  logic                      hi_chan,
    input  logic                      sel_ilv_en,
    input  logic                      gang_en,
    input  logic [1:0]                ilv_code,
    input  logic [ADDR_W-SEL_LSB-1:0] sel_base,
    input  logic [ADDR_W-OFS_LSB-1:0] sel_base_ofs,
    input  logic [HOLE_W-1:0]         hole_ofs,
    input  logic                      hole_valid,
    input  logic [CNT_W-1:0]          chan_count,
    output logic                      chan,
    output logic                      hi_sel,
    output logic [ADDR_W-1:0]         chan_addr,
    output logic                      chan_err
);
    localparam int ILV_LSB = 12;

    logic              hi_d;
    logic              chan_d;
    ofs_src_e          src;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] rebased;
    logic [ADDR_W-1:0] squeezed;
    logic              strip;
    logic              err_d;

    msn_chan_pick #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .SEL_LSB(SEL_LSB), .ILV_LSB(ILV_LSB)
    ) u_pick (
        .addr_i(sys_addr), .node_bits_i(node_ilv_bits), .hi_rng_en_i(hi_rng_en),
        .hi_chan_i(hi_chan), .ilv_en_i(sel_ilv_en), .gang_en_i(gang_en),
        .code_i(ilv_code), .sel_base_i(sel_base), .hi_sel_o(hi_d), .chan_o(chan_d)
    );

    msn_offset_sel #(
        .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .OFS_LSB(OFS_LSB),
        .HOLE_LSB(HOLE_LSB), .HOLE_W(HOLE_W)
    ) u_ofs (
        .addr_i(sys_addr), .hi_sel_i(hi_d), .sel_base_i(sel_base),
        .sel_ofs_i(sel_base_ofs), .hole_ofs_i(hole_ofs), .hole_valid_i(hole_valid),
        .range_base_i(range_base), .src_o(src), .offset_o(offset)
    );

    // Remove the offset, decide channel stripping and range the channel
    always_comb begin
        rebased = sys_addr - offset;
        strip   = sel_ilv_en && !hi_d && !gang_en;
        err_d   = CNT_W'(chan_d) >= chan_count;
    end

    msn_squeeze #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .ILV_LSB(ILV_LSB)
    ) u_sqz (
        .addr_i(rebased), .node_bits_i(node_ilv_bits), .strip_chan_i(strip),
        .code_i(ilv_code), .addr_o(squeezed)
    );

    // Output register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan      <= 1'b0;
            hi_sel    <= 1'b0;
            chan_addr <= '0;
            chan_err  <= 1'b0;
        end else begin
            chan      <= chan_d;
            hi_sel    <= hi_d;
            chan_addr <= squeezed;
            chan_err  <= err_d;
        end
    end

    // R1: ganged mode never reports the high range
    assert_gang_no_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gang_en |=> !hi_sel);
    // R1: without high-range mode the flag stays low
    assert_high_needs_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_rng_en |=> !hi_sel);
    // R2: ganged channel follows address bit 3
    assert_gang_bit3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gang_en |=> (chan == $past(sys_addr[3])));
    // R3: a high-range result carries the programmed channel
    assert_high_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (!hi_sel || chan == $past(hi_chan)));
    // R11: error flag tracks the channel against the configured count
    assert_err_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (chan_err == (CNT_W'(chan) >= $past(chan_count))));
    // R9: the low 12 bits are untouched when no interleave removes them
    assert_low_bits_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ilv_en && range_base[11:0] == 12'h0 && !hole_valid && !hi_rng_en)
        |=> (chan_addr[11:0] == $past(sys_addr[11:0])));
endmodule

// File: tb/msn_chan_norm_test.sv
`timescale 1ns/1ps
// Bench for msn_chan_norm: a vector table walked by one loop, then
// directed checks for reset, latency and the channel-count error.
module msn_chan_norm_test;
    typedef struct packed {
        logic [47:0] addr;
        logic        gang;
        logic        hen;
        logic        hch;
        logic        ilv;
        logic [1:0]  code;
        logic [1:0]  nb;
        logic [20:0] sb;
        logic [21:0] so;
        logic [7:0]  ho;
        logic        hv;
        logic [47:0] rb;
        logic        e_chan;
        logic        e_hi;
        logic [47:0] e_addr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R6 all modes off: channel 0, address passes through
        '{48'h1234, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 21'h0,22'h0,8'h0,1'b0, 48'h0,     1'b0,1'b0,48'h1234, 4'd6},
        // R2 ganged picks bit 3 and blocks the high range (R1)
        '{48'h1238, 1'b1,1'b1,1'b0,1'b0, 2'd0,2'd0, 21'h0,22'h0,8'h0,1'b0, 48'h1000,  1'b1,1'b0,48'h238, 4'd2},
        // R3 high range, R8 high offset, no channel strip (R10)
        '{48'h0900_0040, 1'b0,1'b1,1'b1,1'b1, 2'd0,2'd0, 21'h1,22'h1,8'h0,1'b0, 48'h0, 1'b1,1'b1,48'h0500_0040, 4'd3},
        // R4 code 0 uses bit 6, R10 deletes bit 6
        '{48'h1040, 1'b0,1'b0,1'b0,1'b1, 2'd0,2'd0, 21'h0,22'h0,8'h0,1'b0, 48'h0,     1'b1,1'b0,48'h800, 4'd4},
        // R5 code 2 hash with bit 6
        '{48'h10000, 1'b0,1'b0,1'b0,1'b1, 2'd2,2'd0, 21'h0,22'h0,8'h0,1'b0, 48'h0,    1'b1,1'b0,48'h8000, 4'd5},
        // R5 code 3 hash with bit 9, R10 deletes bit 9
        '{48'h30200, 1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0, 21'h0,22'h0,8'h0,1'b0, 48'h0,    1'b1,1'b0,48'h18000, 4'd5},
        // R6 code 1 uses bit 13 with one node bit; R9 and R10 both squeeze
        '{48'h6123, 1'b0,1'b0,1'b0,1'b1, 2'd1,2'd1, 21'h0,22'h0,8'h0,1'b0, 48'h0,     1'b1,1'b0,48'h1123, 4'd6},
        // R6 interleave off, high mode on, below base: inverse of high channel
        '{48'h500, 1'b0,1'b1,1'b1,1'b0, 2'd0,2'd0, 21'h2,22'h0,8'h0,1'b0, 48'h0,      1'b0,1'b0,48'h500, 4'd6},
        // R7 hole offset above 4 GiB in the low range
        '{48'h1_0000_0100, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 21'h0,22'h0,8'h10,1'b1, 48'h100, 1'b0,1'b0,48'hF800_0100, 4'd7},
        // R8 hole valid but below 4 GiB: range base is used
        '{48'hF000_0000, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 21'h0,22'h0,8'h10,1'b1, 48'h1000_0000, 1'b0,1'b0,48'hE000_0000, 4'd8},
        // R7 high range with base below 4 GiB takes the hole offset
        '{48'h1_0000_0000, 1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0, 21'h1,22'h3,8'h10,1'b1, 48'h0, 1'b0,1'b1,48'hF800_0000, 4'd7},
        // R8 high range with base at 4 GiB keeps the high offset
        '{48'h1_2000_0000, 1'b0,1'b1,1'b1,1'b0, 2'd0,2'd0, 21'h20,22'h8,8'h10,1'b1, 48'h0, 1'b1,1'b1,48'h1_0000_0000, 4'd8},
        // R9 three node bits removed above bit 11
        '{48'h12345, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd3, 21'h0,22'h0,8'h0,1'b0, 48'h0,    1'b0,1'b0,48'h2345, 4'd9},
        // R10 code 1 with two node bits: channel bit 14, then bit 12 deleted
        '{48'h4ABC, 1'b0,1'b0,1'b0,1'b1, 2'd1,2'd2, 21'h0,22'h0,8'h0,1'b0, 48'h0,     1'b1,1'b0,48'hABC, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] sys_addr = '0;
    logic [1:0]  node_ilv_bits = '0;
    logic [47:0] range_base = '0;
    logic        hi_rng_en = 1'b0, hi_chan = 1'b0, sel_ilv_en = 1'b0, gang_en = 1'b0;
    logic [1:0]  ilv_code = '0;
    logic [20:0] sel_base = '0;
    logic [21:0] sel_base_ofs = '0;
    logic [7:0]  hole_ofs = '0;
    logic        hole_valid = 1'b0;
    logic [1:0]  chan_count = 2'd2;
    logic        chan, hi_sel, chan_err;
    logic [47:0] chan_addr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    msn_chan_norm uut (
        .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .node_ilv_bits(node_ilv_bits),
        .range_base(range_base), .hi_rng_en(hi_rng_en), .hi_chan(hi_chan),
        .sel_ilv_en(sel_ilv_en), .gang_en(gang_en), .ilv_code(ilv_code),
        .sel_base(sel_base), .sel_base_ofs(sel_base_ofs), .hole_ofs(hole_ofs),
        .hole_valid(hole_valid), .chan_count(chan_count), .chan(chan),
        .hi_sel(hi_sel), .chan_addr(chan_addr), .chan_err(chan_err)
    );

    // Watchdog: a hung run counts as a failure and still summarizes
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic drive(input vec_t v);
        sys_addr = v.addr; gang_en = v.gang; hi_rng_en = v.hen; hi_chan = v.hch;
        sel_ilv_en = v.ilv; ilv_code = v.code; node_ilv_bits = v.nb;
        sel_base = v.sb; sel_base_ofs = v.so; hole_ofs = v.ho; hole_valid = v.hv;
        range_base = v.rb;
    endtask

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next fall
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R12 reset clears outputs even with live inputs
        @(negedge clk);
        drive(VECS[2]);
        step();
        step();
        check("R12 reset chan", 48'(chan), 48'h0);
        check("R12 reset hi_sel", 48'(hi_sel), 48'h0);
        check("R12 reset addr", chan_addr, 48'h0);
        check("R12 reset err", 48'(chan_err), 48'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            step();
            check($sformatf("R%0d vec%0d chan", VECS[i].req, i), 48'(chan), 48'(VECS[i].e_chan));
            check($sformatf("R%0d vec%0d hi_sel", VECS[i].req, i), 48'(hi_sel), 48'(VECS[i].e_hi));
            check($sformatf("R%0d vec%0d addr", VECS[i].req, i), chan_addr, VECS[i].e_addr);
            check($sformatf("R11 vec%0d err", i), 48'(chan_err), 48'h0);
        end

        // R12 one-cycle latency: new inputs are not visible before the edge
        drive(VECS[0]);
        step();
        drive(VECS[3]);
        #1;
        check("R12 hold before edge", chan_addr, 48'h1234);
        step();
        check("R12 update after edge", chan_addr, 48'h800);

        // R11 channel 1 with a single populated channel
        chan_count = 2'd1;
        step();
        check("R11 chan1 count1", 48'(chan_err), 48'h1);
        // R11 channel 0 with a single populated channel
        drive(VECS[0]);
        step();
        check("R11 chan0 count1", 48'(chan_err), 48'h0);
        // R11 no channel populated
        chan_count = 2'd0;
        step();
        check("R11 chan0 count0", 48'(chan_err), 48'h1);
        chan_count = 2'd2;
        step();

        // R12 reset reasserted mid-run clears the registers again
        drive(VECS[11]);
        rst_n = 1'b0;
        step();
        check("R12 re-reset addr", chan_addr, 48'h0);
        check("R12 re-reset hi", 48'(hi_sel), 48'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule